// File: doc/BRIEF.md
# RS485 Transceiver Driver-Enable Sequencer

This block drives the driver-enable line of an external half-duplex RS485 transceiver for a UART transmitter. A transmit request first turns the driver on. The block then waits a programmed lead time before it tells the serializer to send the start bit. The driver stays on for the whole message. After the last stop bit ends, the driver stays on for a programmed trail time and is then released. The lead and trail times are counted in kernel clock cycles. Each is set by a 5-bit field and scaled by a 4-bit prescale value, with a separate formula when the prescale value is zero. The active level of the enable line can be chosen.

When driver-enable mode is off, the enable line stays at its inactive level and transmit requests pass straight through to the serializer. If a new request arrives while the trail time is still running, the driver stays on and the next character starts at once, without a second lead time.

Top module: `rs485_de_seq`

## Requirements
- R1: With `de_mode_en` low, `de_out` sits at its inactive level, and every `tx_req` pulse gives a one-cycle `tx_go` in the next cycle.
- R2: With `de_pol` = 1 the driver is on when `de_out` = 1. With `de_pol` = 0 the driver is on when `de_out` = 0.
- R3: With `presc` nonzero, `tx_go` rises exactly 1 + `lead_len`×`presc` cycles after the first cycle in which the driver is on.
- R4: With `presc` = 0, that lead interval is 1 + `lead_len` cycles.
- R5: After the clock edge that samples `stop_done`, the driver stays on for exactly 1 + `trail_len`×`presc` cycles (1 + `trail_len` when `presc` = 0), then turns off.
- R6: In enabled mode, `tx_go` is a single-cycle pulse and is raised only after the lead interval, with the driver on throughout.
- R7: A `tx_req` during the trail interval raises `tx_go` in the next cycle, and the driver never turns off in between.
- R8: `tx_req` is ignored during the lead interval and while a character is in progress. `stop_done` is ignored when no character is in progress.
- R9: After reset the driver is off and `tx_go` is low.
- R10: The length fields and `presc` are captured at the edge that starts each interval. Changing them during a countdown does not change its length.
- R11: Clearing `de_mode_en` in the middle of a sequence turns the driver off in the next cycle and cancels the pending `tx_go`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_mode_en | input | 1 | Driver-enable mode on |
| de_pol | input | 1 | 1: driver on when high; 0: driver on when low |
| lead_len | input | 5 | Lead-time field |
| trail_len | input | 5 | Trail-time field |
| presc | input | 4 | Delay prescale value |
| tx_req | input | 1 | Pulse: a character is ready to send |
| stop_done | input | 1 | Pulse: the last stop bit has ended |
| de_out | output | 1 | Transceiver driver enable |
| tx_go | output | 1 | Pulse: the serializer may begin the start bit |

## Verification
A wrong state or count inside the block shows up at the ports as a `tx_go` pulse that arrives early, arrives late, or appears twice. It can also show up as a driver-enable window that is too short, too long, or broken in the middle. Each such fault is visible within one lead or trail interval, so at most a few hundred cycles. The bench measures both intervals in cycles against the formula over random fields, prescale values and polarities. It also drives requests into each phase to expose a wrong transition in the state machine.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;

    localparam int DEF_FIELD_W = 5;
    localparam int DEF_PRE_W   = 4;

    typedef enum logic [1:0] {
        DE_IDLE = 2'd0,
        DE_LEAD = 2'd1,
        DE_ON   = 2'd2,
        DE_TAIL = 2'd3
    } de_state_e;

    // Counter width large enough for 1 + max_field * max_prescale
    function automatic int dly_cnt_w(input int field_w, input int pre_w);
        longint max_len;
        max_len = 64'd1 + ((64'd1 << field_w) - 1) * ((64'd1 << pre_w) - 1);
        return $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/rs485_de_dly.sv
module rs485_de_dly #(
    parameter int FIELD_W = 5,
    parameter int PRE_W   = 4,
    parameter int CNT_W   = 9
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [PRE_W-1:0]   presc,
    output logic [CNT_W-1:0]   len
);
    logic [CNT_W-1:0] prod;

    always_comb begin
        prod = CNT_W'(field) * CNT_W'(presc);
        if (presc == '0)
            len = CNT_W'(field) + CNT_W'(1);
        else
            len = prod + CNT_W'(1);
    end

endmodule

// File: rtl/rs485_de_cnt.sv
module rs485_de_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign last = (cnt == CNT_W'(1));

    // R3: the FSM never asks for a decrement of an exhausted counter
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (rst)
        dec |-> cnt != '0);

    // R5: a loaded interval is never zero cycles long
    p_load_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt != '0);

endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
    import rs485_de_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tx_req,
    input  logic             stop_done,
    input  logic             cnt_last,
    input  logic [CNT_W-1:0] lead_cycles,
    input  logic [CNT_W-1:0] trail_cycles,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             dec,
    output logic             de_act,
    output logic             tx_go
);
    de_state_e state, state_n;
    logic      go_n;

    always_comb begin
        state_n  = state;
        load     = 1'b0;
        load_val = lead_cycles;
        dec      = 1'b0;
        go_n     = 1'b0;
        if (!en) begin
            state_n = DE_IDLE;
            go_n    = tx_req;
        end else begin
            unique case (state)
                DE_IDLE: begin
                    if (tx_req) begin
                        state_n = DE_LEAD;
                        load    = 1'b1;
                    end
                end
                DE_LEAD: begin
                    if (cnt_last) begin
                        state_n = DE_ON;
                        go_n    = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
                DE_ON: begin
                    if (stop_done) begin
                        state_n  = DE_TAIL;
                        load     = 1'b1;
                        load_val = trail_cycles;
                    end
                end
                DE_TAIL: begin
                    if (tx_req) begin
                        state_n = DE_ON;
                        go_n    = 1'b1;
                    end else if (cnt_last) begin
                        state_n = DE_IDLE;
                    end else begin
                        dec = 1'b1;
                    end
                end
                default: state_n = DE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DE_IDLE;
            tx_go <= 1'b0;
        end else begin
            state <= state_n;
            tx_go <= go_n;
        end
    end

    assign de_act = (state != DE_IDLE);

    // R1: mode off forces the driver off one cycle later
    p_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !de_act);

    // R6: in enabled mode tx_go is never two cycles long
    p_go_single_r6: assert property (@(posedge clk) disable iff (rst)
        (en && tx_go) |=> !tx_go);

    // R6: go-ahead while enabled comes only with the driver on
    p_go_with_de_r6: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && tx_go) |-> de_act);

    // R3: an expiring lead interval yields go-ahead next cycle
    p_lead_go_r3: assert property (@(posedge clk) disable iff (rst)
        (en && state == DE_LEAD && cnt_last) |=> tx_go);

    // R7: request during the trail keeps the driver on
    p_retrig_r7: assert property (@(posedge clk) disable iff (rst)
        (en && state == DE_TAIL && tx_req) |=> (de_act && tx_go));

endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq
    import rs485_de_pkg::*;
#(
    parameter int FIELD_W = DEF_FIELD_W,
    parameter int PRE_W   = DEF_PRE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               de_mode_en,
    input  logic               de_pol,
    input  logic [FIELD_W-1:0] lead_len,
    input  logic [FIELD_W-1:0] trail_len,
    input  logic [PRE_W-1:0]   presc,
    input  logic               tx_req,
    input  logic               stop_done,
    output logic               de_out,
    output logic               tx_go
);
    localparam int CNT_W  = dly_cnt_w(FIELD_W, PRE_W);
    localparam int N_DLY  = 2;

    logic [FIELD_W-1:0] fld [N_DLY];
    logic [CNT_W-1:0]   len [N_DLY];
    logic               load, dec, last, de_act;
    logic [CNT_W-1:0]   load_val;

    assign fld[0] = lead_len;
    assign fld[1] = trail_len;

    for (genvar i = 0; i < N_DLY; i++) begin : g_dly
        rs485_de_dly #(
            .FIELD_W(FIELD_W),
            .PRE_W  (PRE_W),
            .CNT_W  (CNT_W)
        ) u_dly (
            .field(fld[i]),
            .presc(presc),
            .len  (len[i])
        );
    end

    rs485_de_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (de_mode_en),
        .tx_req      (tx_req),
        .stop_done   (stop_done),
        .cnt_last    (last),
        .lead_cycles (len[0]),
        .trail_cycles(len[1]),
        .load        (load),
        .load_val    (load_val),
        .dec         (dec),
        .de_act      (de_act),
        .tx_go       (tx_go)
    );

    rs485_de_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .dec     (dec),
        .last    (last)
    );

    assign de_out = de_pol ? de_act : ~de_act;

    // R2: with the mode off the pin rests at the inverse of polarity
    p_pol_rest_r2: assert property (@(posedge clk) disable iff (rst)
        !de_mode_en |=> (de_out == !de_pol));

endmodule

// File: tb/rs485_de_seq_tb.sv
module rs485_de_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, pol = 1'b1, req = 1'b0, stop = 1'b0;
    logic [4:0] lead = '0, trail = '0;
    logic [3:0] presc = '0;
    logic       de, go;
    int         total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_de_seq u_dut (
        .clk(clk), .rst(rst), .de_mode_en(en), .de_pol(pol),
        .lead_len(lead), .trail_len(trail), .presc(presc),
        .tx_req(req), .stop_done(stop), .de_out(de), .tx_go(go)
    );

    function automatic int exp_len(input int f, input int p);
        return (p == 0) ? 1 + f : 1 + f * p;
    endfunction

    function automatic bit de_on();
        return de == pol;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // Starts a request and counts cycles from driver-on to go-ahead
    task automatic measure_lead(input int exp_n, input string tag);
        int k = 0;
        bit de_ok = 1'b1;
        pulse_req();
        while (!go && k < 600) begin
            if (!de_on()) de_ok = 1'b0;
            @(negedge clk); k++;
        end
        check(k == exp_n, tag, k, exp_n);
        check(de_ok && de_on(), "R6 driver on during lead", int'(de_ok), 1);
        @(negedge clk);
        check(!go, "R6 go-ahead single pulse", int'(go), 0);
    endtask

    task automatic measure_trail(input int exp_n, input string tag);
        int k = 0;
        pulse_stop();
        while (de_on() && k < 600) begin
            @(negedge clk); k++;
        end
        check(k == exp_n, tag, k, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        bit seen;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(de == 1'b0, "R9 reset de_out", int'(de), 0);
        check(go == 1'b0, "R9 reset tx_go", int'(go), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 mode off: passthrough and inactive driver, both polarities
        pulse_req();
        check(go == 1'b1, "R1 passthrough go", int'(go), 1);
        check(de == 1'b0, "R1 driver off pol=1", int'(de), 0);
        pol = 1'b0;
        @(negedge clk);
        check(de == 1'b1, "R1 R2 driver off pol=0", int'(de), 1);

        // R2 R3 directed, active low
        en = 1'b1; lead = 5'd4; trail = 5'd2; presc = 4'd3;
        @(negedge clk);
        measure_lead(exp_len(4, 3), "R3 lead P=3");
        check(de == 1'b0, "R2 active-low driver on", int'(de), 0);
        measure_trail(exp_len(2, 3), "R5 trail P=3");
        pol = 1'b1;

        // R4 R5 prescale zero, extremes
        lead = 5'd31; trail = 5'd0; presc = 4'd0;
        measure_lead(exp_len(31, 0), "R4 lead P=0 max field");
        measure_trail(exp_len(0, 0), "R5 trail P=0 zero field");
        lead = 5'd0; presc = 4'd15; trail = 5'd31;
        measure_lead(exp_len(0, 15), "R3 lead zero field");
        measure_trail(exp_len(31, 15), "R5 trail max");

        // R10 fields changed during the lead countdown
        lead = 5'd3; presc = 4'd2;
        pulse_req();
        lead = 5'd20; presc = 4'd9;
        k = 0;
        while (!go && k < 600) begin @(negedge clk); k++; end
        check(k == exp_len(3, 2), "R10 captured lead", k, exp_len(3, 2));
        trail = 5'd5; presc = 4'd1;
        pulse_stop();
        trail = 5'd30; presc = 4'd15;
        k = 0;
        while (de_on() && k < 600) begin @(negedge clk); k++; end
        check(k == exp_len(5, 1), "R10 captured trail", k, exp_len(5, 1));

        // R8 requests during lead and during a character are ignored
        lead = 5'd6; presc = 4'd2; trail = 5'd1;
        pulse_req();
        req = 1'b1; @(negedge clk); req = 1'b0;
        k = 1;
        while (!go && k < 600) begin @(negedge clk); k++; end
        check(k == exp_len(6, 2), "R8 lead unchanged by extra request", k, exp_len(6, 2));
        pulse_req();
        seen = 1'b0;
        repeat (4) begin @(negedge clk); if (go) seen = 1'b1; end
        check(!seen, "R8 request during character ignored", int'(seen), 0);
        measure_trail(exp_len(1, 2), "R5 trail after ignored request");
        pulse_stop();
        check(!de_on(), "R8 stop in idle ignored", int'(de_on()), 0);

        // R7 retrigger during trail
        lead = 5'd2; presc = 4'd3; trail = 5'd10;
        measure_lead(exp_len(2, 3), "R3 lead before retrigger");
        pulse_stop();
        seen = 1'b1;
        repeat (5) begin if (!de_on()) seen = 1'b0; @(negedge clk); end
        req = 1'b1; @(negedge clk); req = 1'b0;
        check(go == 1'b1, "R7 immediate go in trail", int'(go), 1);
        check(seen && de_on(), "R7 driver held", int'(seen && de_on()), 1);
        measure_trail(exp_len(10, 3), "R7 trail after retrigger");

        // R11 disable mid-lead
        lead = 5'd20; presc = 4'd4;
        pulse_req();
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!de_on(), "R11 driver off after disable", int'(de_on()), 0);
        seen = 1'b0;
        repeat (100) begin @(negedge clk); if (go) seen = 1'b1; end
        check(!seen, "R11 pending go cancelled", int'(seen), 0);
        en = 1'b1;

        // R3 R4 R5 random
        for (int i = 0; i < 30; i++) begin
            int lf, tf, pv;
            lf = int'($urandom_range(31, 0));
            tf = int'($urandom_range(31, 0));
            pv = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(15, 1));
            @(negedge clk);
            lead = 5'(lf); trail = 5'(tf); presc = 4'(pv);
            pol = 1'($urandom_range(1, 0));
            @(negedge clk);
            measure_lead(exp_len(lf, pv), "R3 R4 random lead");
            repeat (int'($urandom_range(3, 0))) @(negedge clk);
            measure_trail(exp_len(tf, pv), "R5 random trail");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule